// File: doc/BRIEF.md
# EDID Replication Start-up Sequencer

This controller runs the bring-up of a display receiver's shared EDID store. A start condition arrives from one of three places: a power-up pulse, the first hot-plug event seen since reset, or a restart request made while local power is present. The sequencer then waits a fixed time so that the external EDID EEPROM can power up. After that it reads the EEPROM one byte at a time through a simple request/acknowledge read port and writes each byte into on-chip SRAM. Two fix-ups happen during the copy. The last byte of every 128-byte block is replaced by a freshly computed checksum. The source physical address byte is captured and turned into one variant per display port.

The hot-plug-detect lines of all display ports stay low for the whole sequence. They go high together in the cycle after the fix-up step. From then on the block reports done and the SRAM can answer EDID requests. An enable input removes the block from service. A mode input hands SRAM loading to an external microcontroller. A negative acknowledge, or a read that never completes, parks the block in an error state with the hot-plug lines held low.

Top module: `edid_startup_seq`

## Requirements
- R1: From idle, a one-cycle `pwr_up` pulse starts the sequence. A `hp_event` pulse also starts it, but only if no `hp_event` has been seen since the synchronous reset. Any later `hp_event` leaves the block idle.
- R2: `rd_req` first rises exactly `CLK_MHZ*WAIT_US` clock cycles after the cycle in which the start trigger is sampled. With a read port that answers each byte within four cycles, `done` asserts well within 10 ms.
- R3: Byte i is read from `rd_addr` = i and written to SRAM address i. Writes occur in ascending address order, one for each of `NUM_BYTES` bytes, and carry the data that was read. The only exception is the checksum positions.
- R4: At each address whose offset within its 128-byte block is 127, the written byte is the value that makes the modulo-256 sum of all 128 written bytes of that block equal zero.
- R5: When `done` is high, byte p of `spa_bytes` (bits 8p+7..8p) equals the byte read from address `SPA_ADDR` with one nibble replaced by p+1. The high nibble is replaced when `SPA_HI_NIB` is 1, the low nibble when it is 0.
- R6: `hpd` stays all-zero while the start-up runs and whenever an SRAM write occurs. When copying and fix-up finish, all `hpd` bits and `done` go high together.
- R7: While `repl_en` is low, the block sits idle. It issues no `rd_req` and no SRAM write, and holds `hpd` and `done` low. Dropping `repl_en` during a copy aborts the copy.
- R8: A low `restart_n` while `local_pwr` is high drops `hpd` and `done` in the next cycle and reruns the whole sequence. A low `restart_n` while `local_pwr` is low has no effect.
- R9: If `mode_ext` is 1 at the start, the block issues no reads and holds `hpd` low. In the cycle after `mode_ext` returns to 0, it raises `hpd` and `done` without copying anything.
- R10: An `rd_nack` during the copy sets `err`, keeps `hpd` low and stops all further reads.
- R11: If a pending read receives neither `rd_ack` nor `rd_nack` for `RD_TO` cycles, the block sets `err`, keeps `hpd` low and stops all further reads.
- R12: After the synchronous reset `rst`, the outputs `hpd`, `done`, `err`, `rd_req` and `sram_we` are all low, and the memory of an earlier hot-plug event is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | System power-up pulse |
| hp_event | input | 1 | Hot-plug event pulse |
| restart_n | input | 1 | Active-low restart request |
| local_pwr | input | 1 | Local supply present |
| repl_en | input | 1 | Replication enable |
| mode_ext | input | 1 | 1: SRAM is loaded by an external microcontroller |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | AW | Byte read address |
| rd_ack | input | 1 | Read data valid |
| rd_nack | input | 1 | Read refused |
| rd_data | input | 8 | Read data |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | AW | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| hpd | output | NUM_PORTS | Hot-plug-detect lines |
| spa_bytes | output | 8*NUM_PORTS | Per-port physical address bytes |
| done | output | 1 | Start-up complete |
| err | output | 1 | Read failure |

## Verification
The copy runs over fresh pseudo-random EEPROM images, and the read latency varies from byte to byte. This separates correct address sequencing and data capture from any design that depends on a fixed handshake timing. It also gives every 128-byte block a distinct checksum. Directed runs start the block from a power-up pulse, from a first and from a repeated hot-plug, and from restarts with local power on and off. They also drop the enable in the middle of a copy and use external loading mode, which together tell the start and override paths apart. A negative acknowledge and a stalled read at two different addresses check that the error path stops exactly where the failure happened.

// File: rtl/edid_seq_pkg.sv
package edid_seq_pkg;

    localparam int BLK_BYTES = 128;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR_WAIT,
        ST_COPY,
        ST_FIXUP,
        ST_SERVE,
        ST_EXT,
        ST_ERROR
    } seq_state_t;

    // What the byte at the current copy index means.
    typedef struct packed {
        logic csum_pos;
        logic spa_pos;
        logic last;
    } byte_role_t;

    function automatic logic [7:0] spa_subst(input logic [7:0] b,
                                             input logic [3:0] port_no,
                                             input bit hi);
        return hi ? {port_no, b[3:0]} : {b[7:4], port_no};
    endfunction

endpackage

// File: rtl/edid_wait_timer.sv
module edid_wait_timer #(
    parameter int CYCLES = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    p_wait_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CW'(CYCLES)));

endmodule

// File: rtl/edid_block_sum.sv
module edid_block_sum (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] din,
    output logic [7:0] csum
);
    logic [7:0] sum;

    assign csum = 8'(8'd0 - sum);

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum <= '0;
        else if (add)
            sum <= sum + din;
    end

    p_sum_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum == 8'd0));

endmodule

// File: rtl/edid_spa_gen.sv
module edid_spa_gen
    import edid_seq_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter bit SPA_HI_NIB = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cap,
    input  logic [7:0]             din,
    input  logic                   load,
    output logic [8*NUM_PORTS-1:0] spa_bytes
);
    logic [7:0]             raw_q;
    logic [8*NUM_PORTS-1:0] spa_nx;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign spa_nx[p*8 +: 8] = spa_subst(raw_q, 4'(p + 1), SPA_HI_NIB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q     <= '0;
            spa_bytes <= '0;
        end else begin
            if (cap)
                raw_q <= din;
            if (load)
                spa_bytes <= spa_nx;
        end
    end

endmodule

// File: rtl/edid_startup_seq.sv
module edid_startup_seq
    import edid_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 250,
    parameter int WAIT_US    = 100,
    parameter int NUM_BYTES  = 256,
    parameter int RD_TO      = 1024,
    parameter int NUM_PORTS  = 4,
    parameter int SPA_ADDR   = 160,
    parameter bit SPA_HI_NIB = 1'b1,
    localparam int AW        = $clog2(NUM_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pwr_up,
    input  logic                   hp_event,
    input  logic                   restart_n,
    input  logic                   local_pwr,
    input  logic                   repl_en,
    input  logic                   mode_ext,
    output logic                   rd_req,
    output logic [AW-1:0]          rd_addr,
    input  logic                   rd_ack,
    input  logic                   rd_nack,
    input  logic [7:0]             rd_data,
    output logic                   sram_we,
    output logic [AW-1:0]          sram_addr,
    output logic [7:0]             sram_wdata,
    output logic [NUM_PORTS-1:0]   hpd,
    output logic [8*NUM_PORTS-1:0] spa_bytes,
    output logic                   done,
    output logic                   err
);
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int TOW      = $clog2(RD_TO + 1);

    seq_state_t    state, st_nx, st_tgt;
    logic [AW-1:0] idx;
    logic [TOW-1:0] to_cnt;
    logic          hp_seen;
    logic          restart, start_trig, expired, wr_fire;
    logic [7:0]    csum;
    byte_role_t    role;

    assign restart    = !restart_n && local_pwr;
    assign start_trig = pwr_up || (hp_event && !hp_seen);
    assign st_tgt     = mode_ext ? ST_EXT : ST_PWR_WAIT;

    assign role.csum_pos = ((32'(idx) % BLK_BYTES) == BLK_BYTES - 1);
    assign role.spa_pos  = (32'(idx) == 32'(SPA_ADDR));
    assign role.last     = (32'(idx) == 32'(NUM_BYTES - 1));

    assign wr_fire = (state == ST_COPY) && rd_ack && !rd_nack && repl_en && !restart;

    edid_wait_timer #(.CYCLES(WAIT_CYC)) i_wait (
        .clk     (clk),
        .rst     (rst),
        .run     ((state == ST_PWR_WAIT) && !restart),
        .expired (expired)
    );

    edid_block_sum i_sum (
        .clk  (clk),
        .rst  (rst),
        .clr  ((state != ST_COPY) || (wr_fire && role.csum_pos)),
        .add  (wr_fire && !role.csum_pos),
        .din  (rd_data),
        .csum (csum)
    );

    edid_spa_gen #(.NUM_PORTS(NUM_PORTS), .SPA_HI_NIB(SPA_HI_NIB)) i_spa (
        .clk       (clk),
        .rst       (rst),
        .cap       (wr_fire && role.spa_pos),
        .din       (rd_data),
        .load      (state == ST_FIXUP),
        .spa_bytes (spa_bytes)
    );

    always_comb begin
        st_nx = state;
        unique case (state)
            ST_IDLE:     if (start_trig) st_nx = st_tgt;
            ST_PWR_WAIT: if (expired) st_nx = ST_COPY;
            ST_COPY: begin
                if (rd_nack || (!rd_ack && to_cnt == TOW'(RD_TO - 1)))
                    st_nx = ST_ERROR;
                else if (rd_ack && role.last)
                    st_nx = ST_FIXUP;
            end
            ST_FIXUP:    st_nx = ST_SERVE;
            ST_EXT:      if (!mode_ext) st_nx = ST_SERVE;
            default:     st_nx = state;
        endcase
        if (restart)  st_nx = st_tgt;
        if (!repl_en) st_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            idx        <= '0;
            to_cnt     <= '0;
            hp_seen    <= 1'b0;
            sram_we    <= 1'b0;
            sram_addr  <= '0;
            sram_wdata <= '0;
        end else begin
            state   <= st_nx;
            sram_we <= wr_fire;
            if (hp_event)
                hp_seen <= 1'b1;
            if (state != ST_COPY)
                idx <= '0;
            else if (wr_fire)
                idx <= idx + 1'b1;
            if (state != ST_COPY || rd_ack || rd_nack)
                to_cnt <= '0;
            else
                to_cnt <= to_cnt + 1'b1;
            if (wr_fire) begin
                sram_addr  <= idx;
                sram_wdata <= role.csum_pos ? csum : rd_data;
            end
        end
    end

    assign rd_req  = (state == ST_COPY);
    assign rd_addr = idx;
    assign done    = (state == ST_SERVE);
    assign err     = (state == ST_ERROR);
    assign hpd     = {NUM_PORTS{state == ST_SERVE}};

    p_hpd_low_on_write_r6: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (hpd == '0));

    p_disable_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !repl_en |=> (!rd_req && !sram_we && hpd == '0 && !done));

    p_restart_drops_hpd_r8: assert property (@(posedge clk) disable iff (rst)
        (!restart_n && local_pwr && repl_en) |=> (hpd == '0 && !done));

    p_unpowered_reset_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!restart_n && !local_pwr && repl_en && done) |=> done);

    p_ext_no_read_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXT && mode_ext && repl_en && !restart) |=> (!rd_req && hpd == '0));

    p_nack_error_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_nack && repl_en && !restart) |=> (err && hpd == '0));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (err && repl_en && !restart) |=> (err && !rd_req));

endmodule

// File: tb/test_edid_startup_seq.sv
module test_edid_startup_seq;

    localparam int CLK_MHZ   = 250;
    localparam int WAIT_US   = 1;
    localparam int WAIT_CYC  = CLK_MHZ * WAIT_US;
    localparam int NB        = 256;
    localparam int RD_TO     = 16;
    localparam int NP        = 4;
    localparam int SPA_ADDR  = 160;
    localparam int AW        = 8;

    logic clk = 1'b0;
    logic rst, pwr_up, hp_event, restart_n, local_pwr, repl_en, mode_ext;
    logic rd_req, rd_ack, rd_nack, sram_we, done, err;
    logic [AW-1:0] rd_addr, sram_addr;
    logic [7:0] rd_data, sram_wdata;
    logic [NP-1:0] hpd;
    logic [8*NP-1:0] spa_bytes;

    int checks = 0;
    int errors = 0;

    logic [7:0] eep [NB];
    logic [7:0] wr_mem [NB];
    int wr_cnt, order_err, hpd_bad, rd_seen;
    int lat_cnt = 0, lat_tgt = 0;
    bit nack_en = 0, stall_en = 0;
    int nack_addr = 0, stall_addr = 0;

    always #2 clk = ~clk;

    edid_startup_seq #(
        .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .NUM_BYTES(NB), .RD_TO(RD_TO),
        .NUM_PORTS(NP), .SPA_ADDR(SPA_ADDR), .SPA_HI_NIB(1'b1)
    ) i_edid_startup_seq (
        .clk(clk), .rst(rst), .pwr_up(pwr_up), .hp_event(hp_event),
        .restart_n(restart_n), .local_pwr(local_pwr), .repl_en(repl_en),
        .mode_ext(mode_ext), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_nack(rd_nack), .rd_data(rd_data),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .hpd(hpd), .spa_bytes(spa_bytes), .done(done), .err(err)
    );

    // Read-port model: variable latency, optional refusal or stall.
    always @(negedge clk) begin
        rd_ack  = 1'b0;
        rd_nack = 1'b0;
        if (rd_req) begin
            if (stall_en && int'(rd_addr) == stall_addr) begin
                lat_cnt = 0;
            end else if (lat_cnt >= lat_tgt) begin
                if (nack_en && int'(rd_addr) == nack_addr)
                    rd_nack = 1'b1;
                else begin
                    rd_ack  = 1'b1;
                    rd_data = eep[rd_addr];
                end
                lat_cnt = 0;
                lat_tgt = int'($urandom % 4);
            end else
                lat_cnt++;
        end else
            lat_cnt = 0;
    end

    // Write and HPD monitor.
    always @(negedge clk) begin
        if (rd_req) rd_seen++;
        if (sram_we) begin
            if (int'(sram_addr) != wr_cnt) order_err++;
            wr_mem[sram_addr] = sram_wdata;
            wr_cnt++;
            if (hpd != '0) hpd_bad++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        wr_cnt = 0; order_err = 0; hpd_bad = 0; rd_seen = 0;
    endtask

    task automatic fill_eep();
        for (int i = 0; i < NB; i++) eep[i] = 8'($urandom);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_pwr();
        @(negedge clk) pwr_up = 1'b1;
        @(negedge clk) pwr_up = 1'b0;
    endtask

    task automatic pulse_hp();
        @(negedge clk) hp_event = 1'b1;
        @(negedge clk) hp_event = 1'b0;
    endtask

    task automatic wait_end(output int cyc);
        cyc = 0;
        while (!done && !err && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        logic [7:0] s;
        int base;
        if (i % 128 != 127) return eep[i];
        s = 8'd0;
        base = i - 127;
        for (int k = 0; k < 127; k++) s = s + eep[base + k];
        return 8'(8'd0 - s);
    endfunction

    function automatic logic [7:0] exp_spa(input int p);
        return {4'(p + 1), eep[SPA_ADDR][3:0]};
    endfunction

    task automatic verify_image(input string tag);
        int bad;
        logic [7:0] s;
        bad = 0;
        for (int i = 0; i < NB; i++) if (wr_mem[i] !== exp_byte(i)) bad++;
        chk({"R3 image mismatches ", tag}, bad, 0);
        chk({"R3 write count ", tag}, wr_cnt, NB);
        chk({"R3 write order ", tag}, order_err, 0);
        for (int b = 0; b < NB / 128; b++) begin
            s = 8'd0;
            for (int k = 0; k < 128; k++) s = s + wr_mem[b*128 + k];
            chk({"R4 block sum ", tag}, 32'(s), 0);
        end
        for (int p = 0; p < NP; p++)
            chk({"R5 spa byte ", tag}, 32'(spa_bytes[p*8 +: 8]), 32'(exp_spa(p)));
        chk({"R6 hpd low during writes ", tag}, hpd_bad, 0);
        chk({"R6 done ", tag}, done, 1);
        chk({"R6 hpd all high ", tag}, 32'(hpd), 32'hf);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, cyc, snap;
        void'($urandom(32'd7731));
        rst = 1'b1; pwr_up = 0; hp_event = 0; restart_n = 1; local_pwr = 1;
        repl_en = 1; mode_ext = 0; rd_ack = 0; rd_nack = 0; rd_data = 0;
        clr_mon();
        do_reset();
        @(negedge clk);
        // R12 reset state
        chk("R12 hpd", 32'(hpd), 0);
        chk("R12 done", done, 0);
        chk("R12 err", err, 0);
        chk("R12 rd_req", rd_req, 0);
        chk("R12 sram_we", sram_we, 0);

        // R2 wait length, then full run from power-up
        fill_eep(); clr_mon();
        @(negedge clk) pwr_up = 1'b1;
        @(negedge clk) pwr_up = 1'b0;
        n = 1;
        while (!rd_req && n < 5000) begin @(negedge clk); n++; end
        chk("R2 cycles to first read", n, WAIT_CYC + 1);
        chk("R6 hpd low at copy start", 32'(hpd), 0);
        wait_end(cyc);
        chk("R2 within 10 ms", (n + cyc) < 2500000, 1);
        verify_image("pwrup");

        // R1 start from first hot-plug
        do_reset();
        fill_eep(); clr_mon();
        pulse_hp();
        wait_end(cyc);
        chk("R1 first hot-plug starts", done, 1);
        verify_image("hotplug");

        // R7 idle while disabled
        @(negedge clk) repl_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 hpd low when disabled", 32'(hpd), 0);
        chk("R7 done low when disabled", done, 0);
        @(negedge clk) repl_en = 1'b1;

        // R1 repeated hot-plug ignored
        clr_mon();
        pulse_hp();
        repeat (WAIT_CYC + 100) @(negedge clk);
        chk("R1 second hot-plug no read", rd_seen, 0);
        chk("R1 second hot-plug no done", done, 0);

        // R8 restart with and without local power
        fill_eep(); clr_mon();
        pulse_pwr();
        wait_end(cyc);
        verify_image("pwrup2");
        clr_mon();
        @(negedge clk) begin local_pwr = 1'b0; restart_n = 1'b0; end
        repeat (20) @(negedge clk);
        chk("R8 unpowered restart keeps done", done, 1);
        chk("R8 unpowered restart keeps hpd", 32'(hpd), 32'hf);
        chk("R8 unpowered restart no read", rd_seen, 0);
        restart_n = 1'b1; local_pwr = 1'b1;
        @(negedge clk);
        fill_eep(); clr_mon();
        restart_n = 1'b0;
        @(negedge clk);
        chk("R8 restart drops hpd", 32'(hpd), 0);
        chk("R8 restart drops done", done, 0);
        repeat (4) @(negedge clk);
        restart_n = 1'b1;
        wait_end(cyc);
        verify_image("restart");

        // R7 abort mid-copy
        do_reset();
        fill_eep(); clr_mon();
        pulse_pwr();
        while (wr_cnt < 40) @(negedge clk);
        repl_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 abort rd_req", rd_req, 0);
        chk("R7 abort hpd", 32'(hpd), 0);
        snap = wr_cnt; rd_seen = 0;
        repeat (50) @(negedge clk);
        chk("R7 abort no writes", wr_cnt, snap);
        chk("R7 abort no reads", rd_seen, 0);
        chk("R7 abort done low", done, 0);
        repl_en = 1'b1;

        // R9 external loading
        @(negedge clk) mode_ext = 1'b1;
        clr_mon();
        pulse_pwr();
        repeat (WAIT_CYC + 100) @(negedge clk);
        chk("R9 no reads", rd_seen, 0);
        chk("R9 hpd low", 32'(hpd), 0);
        chk("R9 done low", done, 0);
        mode_ext = 1'b0;
        @(negedge clk);
        chk("R9 done after release", done, 1);
        chk("R9 hpd after release", 32'(hpd), 32'hf);
        chk("R9 no writes", wr_cnt, 0);

        // R10 refused read
        do_reset();
        fill_eep(); clr_mon();
        nack_en = 1; nack_addr = 37;
        pulse_pwr();
        wait_end(cyc);
        chk("R10 err set", err, 1);
        chk("R10 hpd low", 32'(hpd), 0);
        chk("R10 writes before refusal", wr_cnt, 37);
        rd_seen = 0;
        repeat (30) @(negedge clk);
        chk("R10 no further reads", rd_seen, 0);
        nack_en = 0;

        // R11 stalled read
        do_reset();
        fill_eep(); clr_mon();
        stall_en = 1; stall_addr = 200;
        pulse_pwr();
        wait_end(cyc);
        chk("R11 err set", err, 1);
        chk("R11 hpd low", 32'(hpd), 0);
        chk("R11 writes before stall", wr_cnt, 200);
        rd_seen = 0;
        repeat (30) @(negedge clk);
        chk("R11 no further reads", rd_seen, 0);
        stall_en = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule